// File: doc/BRIEF.md
# Single-Transfer Bus Master for a Classic-Cycle Shared Bus

This block turns one request from a local command port into a single Wishbone classic-cycle transfer. The transfer is either a read or a write. A request carries a direction flag, an address, write data and byte selects. When the block accepts a request, it raises the cycle and strobe outputs together, with the address, direction, data and selects already set. It keeps all of them steady through any number of slave wait states. It ends the transfer on the first rising edge where the slave shows acknowledge, error or retry.

After each transfer, the block sends a one-cycle completion pulse to the local side. The pulse carries a status code that names the signal that ended the transfer, and for an acknowledged read it also carries the read data. Master and slave run on one common clock, and every bus output comes from a register.

The request side uses a valid/ready pair with one rule for back-pressure. A request is taken only on an edge where `cmd_valid` and `cmd_ready` are both high. A request presented while `cmd_ready` is low is dropped rather than queued, so the source must hold `cmd_valid` until it sees `cmd_ready`. The completion side is a plain pulse with no back-pressure.

Top module: `wb_single_master`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `wb_cyc_o`, `wb_stb_o` and `rsp_valid` are low, `busy` is low and `cmd_ready` is high.
- R2: After an edge where `cmd_valid` and `cmd_ready` are both high, `wb_cyc_o` and `wb_stb_o` are high in the next cycle, and in that cycle `wb_we_o`, `wb_adr_o`, `wb_dat_o` and `wb_sel_o` equal `cmd_write`, `cmd_addr`, `cmd_wdata` and `cmd_sel` as sampled at that edge.
- R3: On an edge where `wb_stb_o` is high and none of `wb_ack_i`, `wb_err_i`, `wb_rty_i` is high, the strobe, cycle, address, direction, write data and selects all keep their values into the next cycle, with no limit on the number of wait states.
- R4: After an edge where `wb_stb_o` is high and at least one termination input is high, `wb_cyc_o` and `wb_stb_o` are both low in the next cycle.
- R5: In the cycle after a terminating edge, `rsp_valid` is high for exactly one cycle. `rsp_status` is 2'b00 for acknowledge, 2'b01 for error and 2'b10 for retry. When several termination inputs are high together, error wins over retry, and retry wins over acknowledge.
- R6: When a read ends with acknowledge alone, `rsp_rdata` holds the `wb_dat_i` value sampled at the terminating edge. For a write, or for any error or retry ending, `rsp_rdata` is zero. The status and the data both hold until the next completion.
- R7: `busy` is high, and `cmd_ready` is low, from the cycle after a request is accepted through the one idle cycle that follows termination. In that idle cycle `wb_cyc_o` stays low.
- R8: A request presented while `busy` is high starts no transfer and does not change any bus output.
- R9: One acknowledge ends exactly one transfer. If the slave keeps a termination input high after the terminating edge, no new cycle begins and no further completion is reported unless a new request is accepted.
- R10: A termination input that is high while `wb_stb_o` is low produces no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for the bus and the local side |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A transfer request is presented |
| cmd_ready | output | 1 | The block will take a request on this edge |
| cmd_write | input | 1 | 1 for a write, 0 for a read |
| cmd_addr | input | AW | Transfer address |
| cmd_wdata | input | DW | Write data |
| cmd_sel | input | DW/8 | Byte selects |
| busy | output | 1 | A transfer or its closing idle cycle is in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | Termination code: 00 ack, 01 err, 10 rty |
| rsp_rdata | output | DW | Read data of an acknowledged read, otherwise zero |
| wb_cyc_o | output | 1 | Bus cycle in progress |
| wb_stb_o | output | 1 | Transfer strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | AW | Address |
| wb_dat_o | output | DW | Write data to the slave |
| wb_sel_o | output | DW/8 | Byte selects to the slave |
| wb_dat_i | input | DW | Read data from the slave |
| wb_ack_i | input | 1 | Normal termination |
| wb_err_i | input | 1 | Error termination |
| wb_rty_i | input | 1 | Retry termination |

## Verification
Some handshake rules are checked by the assertions on every clock. The strobe never rises without the cycle signal. The strobe and all bus fields stay put through wait states, and both control lines drop after a terminating edge. A completion pulse lasts one cycle and always follows a sampled termination. The cycle line stays low for at least one cycle after it falls.

Other behaviour is visible only through the bench's scenarios, which compare the block with a reference model on every clock:
- the status code chosen when several termination inputs arrive together,
- the read data captured on acknowledge and the zero data after error or retry,
- requests dropped while busy,
- a slave that holds acknowledge high too long,
- termination inputs that arrive outside a cycle.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BUS  = 2'd1,
    PH_REST = 2'd2
  } wbm_phase_e;

  typedef enum logic [1:0] {
    END_ACK = 2'b00,
    END_ERR = 2'b01,
    END_RTY = 2'b10
  } wbm_end_e;
endpackage

// File: rtl/wbm_term_decode.sv
module wbm_term_decode
  import wbm_pkg::*;
(
  input  logic     ack,
  input  logic     err,
  input  logic     rty,
  output logic     any_end,
  output logic     ack_only,
  output wbm_end_e code
);
  always_comb begin
    any_end  = ack | err | rty;
    ack_only = ack & ~err & ~rty;
    if (err)      code = END_ERR;
    else if (rty) code = END_RTY;
    else          code = END_ACK;
  end
endmodule

// File: rtl/wbm_ctrl.sv
module wbm_ctrl
  import wbm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic any_end,
  output logic launch,
  output logic finish,
  output logic cyc,
  output logic stb,
  output logic busy,
  output logic ready
);
  wbm_phase_e phase_q, phase_d;

  always_comb begin
    ready   = (phase_q == PH_IDLE);
    busy    = ~ready;
    launch  = ready & req_valid;
    finish  = (phase_q == PH_BUS) & any_end;
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (req_valid) phase_d = PH_BUS;
      PH_BUS:  if (any_end)   phase_d = PH_REST;
      PH_REST: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cyc     <= 1'b0;
      stb     <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (launch) begin
        cyc <= 1'b1;
        stb <= 1'b1;
      end else if (finish) begin
        cyc <= 1'b0;
        stb <= 1'b0;
      end
    end
  end

  AST_STB_NEEDS_CYC: assert property (@(posedge clk) disable iff (rst)
    stb |-> cyc); // R2
  AST_STB_HELD: assert property (@(posedge clk) disable iff (rst)
    (stb && !any_end) |=> (stb && cyc)); // R3
  AST_DROP_ON_END: assert property (@(posedge clk) disable iff (rst)
    (stb && any_end) |=> (!stb && !cyc)); // R4
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(cyc) |=> !cyc); // R7
  AST_BUSY_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cyc |-> (busy && !ready)); // R7
endmodule

// File: rtl/wbm_bus_regs.sv
module wbm_bus_regs #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          in_we,
  input  logic [AW-1:0] in_adr,
  input  logic [DW-1:0] in_dat,
  input  logic [SW-1:0] in_sel,
  output logic          we_o,
  output logic [AW-1:0] adr_o,
  output logic [DW-1:0] dat_o,
  output logic [SW-1:0] sel_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      we_o  <= 1'b0;
      adr_o <= '0;
      dat_o <= '0;
      sel_o <= '0;
    end else if (load) begin
      we_o  <= in_we;
      adr_o <= in_adr;
      dat_o <= in_dat;
      sel_o <= in_sel;
    end
  end
endmodule

// File: rtl/wbm_resp.sv
module wbm_resp
  import wbm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          finish,
  input  logic          ack_only,
  input  logic          was_write,
  input  wbm_end_e      code,
  input  logic [DW-1:0] rd_in,
  output logic          done,
  output logic [1:0]    status,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      status <= 2'b00;
      rdata  <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        status <= code;
        rdata  <= (ack_only && !was_write) ? rd_in : '0;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    done |-> (status != 2'b11)); // R5
endmodule

// File: rtl/wb_single_master.sv
module wb_single_master
  import wbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [SW-1:0] cmd_sel,
  output logic          busy,
  output logic          rsp_valid,
  output logic [1:0]    rsp_status,
  output logic [DW-1:0] rsp_rdata,
  output logic          wb_cyc_o,
  output logic          wb_stb_o,
  output logic          wb_we_o,
  output logic [AW-1:0] wb_adr_o,
  output logic [DW-1:0] wb_dat_o,
  output logic [SW-1:0] wb_sel_o,
  input  logic [DW-1:0] wb_dat_i,
  input  logic          wb_ack_i,
  input  logic          wb_err_i,
  input  logic          wb_rty_i
);
  logic     any_end, ack_only, launch, finish;
  wbm_end_e code;

  wbm_term_decode u_dec (
    .ack(wb_ack_i), .err(wb_err_i), .rty(wb_rty_i),
    .any_end(any_end), .ack_only(ack_only), .code(code)
  );

  wbm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req_valid(cmd_valid), .any_end(any_end),
    .launch(launch), .finish(finish), .cyc(wb_cyc_o), .stb(wb_stb_o),
    .busy(busy), .ready(cmd_ready)
  );

  wbm_bus_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .load(launch),
    .in_we(cmd_write), .in_adr(cmd_addr), .in_dat(cmd_wdata), .in_sel(cmd_sel),
    .we_o(wb_we_o), .adr_o(wb_adr_o), .dat_o(wb_dat_o), .sel_o(wb_sel_o)
  );

  wbm_resp #(.DW(DW)) u_resp (
    .clk(clk), .rst(rst), .finish(finish), .ack_only(ack_only),
    .was_write(wb_we_o), .code(code), .rd_in(wb_dat_i),
    .done(rsp_valid), .status(rsp_status), .rdata(rsp_rdata)
  );

  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wb_stb_o && !(wb_ack_i || wb_err_i || wb_rty_i)) |=>
      ($stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o) && $stable(wb_sel_o))); // R3
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(wb_stb_o && (wb_ack_i || wb_err_i || wb_rty_i))); // R5
  AST_NO_DONE_OFF_BUS: assert property (@(posedge clk) disable iff (rst)
    (!wb_stb_o) |=> !rsp_valid); // R10
  AST_BUSY_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
    busy != cmd_ready); // R7
endmodule

// File: tb/wb_single_master_test.sv
module wb_single_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = DW / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0, wb_dat_i = '0;
  logic [SW-1:0] cmd_sel = '0;
  logic wb_ack_i = 1'b0, wb_err_i = 1'b0, wb_rty_i = 1'b0;
  logic cmd_ready, busy, rsp_valid, wb_cyc_o, wb_stb_o, wb_we_o;
  logic [1:0] rsp_status;
  logic [DW-1:0] rsp_rdata, wb_dat_o;
  logic [AW-1:0] wb_adr_o;
  logic [SW-1:0] wb_sel_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_single_master #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_sel(cmd_sel), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .wb_cyc_o(wb_cyc_o),
    .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o), .wb_adr_o(wb_adr_o),
    .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel_o), .wb_dat_i(wb_dat_i),
    .wb_ack_i(wb_ack_i), .wb_err_i(wb_err_i), .wb_rty_i(wb_rty_i)
  );

  // Behavioural reference model: 0 idle, 1 on bus, 2 rest
  int m_phase = 0;
  bit m_cyc = 0, m_rv = 0, m_we = 0;
  int unsigned m_status = 0;
  logic [AW-1:0] m_adr = '0;
  logic [DW-1:0] m_dat = '0, m_rdata = '0;
  logic [SW-1:0] m_sel = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_cyc = 0; m_rv = 0; m_status = 0; m_rdata = '0;
      m_we = 0; m_adr = '0; m_dat = '0; m_sel = '0;
    end else begin
      m_rv = 0;
      if (m_phase == 0) begin
        if (cmd_valid) begin
          m_phase = 1; m_cyc = 1;
          m_we = cmd_write; m_adr = cmd_addr; m_dat = cmd_wdata; m_sel = cmd_sel;
        end
      end else if (m_phase == 1) begin
        if (wb_ack_i || wb_err_i || wb_rty_i) begin
          m_phase = 2; m_cyc = 0; m_rv = 1;
          m_status = wb_err_i ? 1 : (wb_rty_i ? 2 : 0);
          m_rdata = (m_status == 0 && !m_we) ? wb_dat_i : '0;
        end
      end else begin
        m_phase = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2/R4 cyc", 64'(wb_cyc_o), 64'(m_cyc));
    chk("R2/R4 stb", 64'(wb_stb_o), 64'(m_cyc));
    chk("R2/R3 we", 64'(wb_we_o), 64'(m_we));
    chk("R2/R3 adr", 64'(wb_adr_o), 64'(m_adr));
    chk("R2/R3 dat_o", 64'(wb_dat_o), 64'(m_dat));
    chk("R2/R3 sel", 64'(wb_sel_o), 64'(m_sel));
    chk("R7 busy", 64'(busy), 64'(m_phase != 0));
    chk("R7 ready", 64'(cmd_ready), 64'(m_phase == 0));
    chk("R5 rsp_valid", 64'(rsp_valid), 64'(m_rv));
    chk("R5 status", 64'(rsp_status), 64'(m_status));
    chk("R6 rdata", 64'(rsp_rdata), 64'(m_rdata));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_txn(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [SW-1:0] s, input int waits,
                         input bit ak, input bit er, input bit rt, input bit intrude,
                         input int hold_extra);
    cmd_valid = 1; cmd_write = w; cmd_addr = a; cmd_wdata = d; cmd_sel = s;
    tick();
    cmd_valid = 0;
    for (int i = 0; i < waits; i++) begin
      if (intrude && i == 0) begin
        cmd_valid = 1; cmd_addr = ~a; cmd_write = ~w;
      end
      tick();
      cmd_valid = 0;
      chk("R8 adr kept under busy request", 64'(wb_adr_o), 64'(a));
      chk("R3 stb held in wait state", 64'(wb_stb_o), 64'd1);
    end
    wb_ack_i = ak; wb_err_i = er; wb_rty_i = rt; wb_dat_i = d ^ 32'h5A5A_0F0F;
    tick();
    chk("R5 done pulse", 64'(rsp_valid), 64'd1);
    chk("R4 cyc dropped", 64'(wb_cyc_o), 64'd0);
    for (int i = 0; i < hold_extra; i++) begin
      tick();
      chk("R9 no extra cycle from held ack", 64'(wb_cyc_o), 64'd0);
    end
    wb_ack_i = 0; wb_err_i = 0; wb_rty_i = 0;
    tick();
    tick();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    chk("R1 reset cyc", 64'(wb_cyc_o), 64'd0);
    chk("R1 reset ready", 64'(cmd_ready), 64'd1);
    chk("R1 reset busy", 64'(busy), 64'd0);
    // R2 R5: write, immediate ack
    run_txn(1, 32'h0000_1000, 32'hDEAD_BEEF, 4'hF, 0, 1, 0, 0, 0, 0);
    // R6: read with three wait states, ack
    run_txn(0, 32'h0000_2004, 32'h1234_5678, 4'h3, 3, 1, 0, 0, 0, 0);
    chk("R6 read data", 64'(rsp_rdata), 64'(32'h1234_5678 ^ 32'h5A5A_0F0F));
    // R5: read ended by error, rdata zero
    run_txn(0, 32'h0000_3008, 32'hAAAA_5555, 4'hC, 2, 0, 1, 0, 0, 0);
    chk("R5 err status", 64'(rsp_status), 64'd1);
    chk("R6 zero data on err", 64'(rsp_rdata), 64'd0);
    // R5: write ended by retry
    run_txn(1, 32'h0000_400C, 32'h0BAD_F00D, 4'h1, 1, 0, 0, 1, 0, 0);
    chk("R5 rty status", 64'(rsp_status), 64'd2);
    // R5 priority: ack+rty+err together on read
    run_txn(0, 32'h0000_5010, 32'h7777_1111, 4'hF, 1, 1, 1, 1, 0, 0);
    chk("R5 err wins", 64'(rsp_status), 64'd1);
    run_txn(0, 32'h0000_5014, 32'h7777_2222, 4'hF, 0, 1, 0, 1, 0, 0);
    chk("R5 rty beats ack", 64'(rsp_status), 64'd2);
    // R8: request while busy is dropped
    run_txn(1, 32'h0000_6000, 32'h0102_0304, 4'h6, 4, 1, 0, 0, 1, 0);
    chk("R8 no new cycle after drop", 64'(wb_cyc_o), 64'd0);
    // R9: slave holds ack after termination
    run_txn(0, 32'h0000_7000, 32'hCAFE_0001, 4'hF, 1, 1, 0, 0, 0, 3);
    // R10: termination inputs while idle
    wb_ack_i = 1; wb_err_i = 1;
    tick(); tick();
    chk("R10 no done while idle", 64'(rsp_valid), 64'd0);
    wb_ack_i = 0; wb_err_i = 0;
    tick();
    // R7: back-to-back requests, long wait
    run_txn(1, 32'h0000_8000, 32'h0000_0042, 4'h8, 12, 1, 0, 0, 0, 0);
    run_txn(0, 32'h0000_8004, 32'h0000_0043, 4'h8, 0, 1, 0, 0, 0, 0);
    // R1: reset mid-cycle
    cmd_valid = 1; cmd_addr = 32'h9000; tick(); cmd_valid = 0;
    rst = 1; tick(); rst = 0; tick();
    chk("R1 reset clears cycle", 64'(wb_cyc_o), 64'd0);
    chk("R1 reset ready again", 64'(cmd_ready), 64'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule